// File: doc/BRIEF.md
# Region-to-Leaf-Entry Mapping Sequencer

This block turns one mapping job into the ordered stream of leaf-entry writes that a four-level, 4KB-granule translation table needs for that region. A job gives a virtual start, a physical start, a byte length, two policy flags and an attribute field that is passed through unchanged. The sequencer walks the region from low to high addresses. At each step it emits the largest leaf that fits: a 1GB block (level 1), a 2MB block (level 2) or a 4KB page (level 3). It also marks entries that belong to a fully aligned 16-entry group with a contiguous hint.

The caller offers a job while the sequencer is idle. It then drains commands over a valid/ready pair, and waits for a one-cycle done pulse, or for an error pulse if the job was refused. Allocating intermediate tables and writing table-pointer entries are the caller's concern. The command carries the virtual address of the entry, so the caller can locate the slot.

Top module: `region_map_seq`

## Requirements
- R1: After reset `job_ready_o` is 1, and `cmd_valid_o`, `done_o` and `err_o` are 0.
- R2: A job whose virtual and physical starts differ in bits [11:0] is refused. `err_o` pulses for one cycle, no command is emitted and `done_o` stays 0.
- R3: A job of length 0 (with matching page offsets) emits no command and produces a single `done_o` pulse.
- R4: The virtual and physical starts are rounded down to a 4KB boundary, and the end (start plus length) is rounded up to a 4KB boundary before any entry is produced.
- R5: A level-1 command (`cmd_level_o` = 1) covers 1GB. It is produced when the current virtual address, the end of its piece (the next 1GB boundary or the job end, whichever comes first) and the physical address are all 1GB-aligned and `job_no_blk_i` was 0.
- R6: Where no level-1 block fits, a level-2 command (`cmd_level_o` = 2) covering 2MB is produced under the same rule at 2MB granularity.
- R7: Otherwise level-3 commands (`cmd_level_o` = 3) are produced one per 4KB page. After every command both addresses advance by the size the entry covers. The last entry ends exactly at the rounded job end.
- R8: With `job_no_blk_i` = 1 only level-3 commands are produced.
- R9: A page carries `cmd_cont_o` = 1 when its aligned 64KB group (16 pages) lies wholly inside the job and the virtual and physical addresses agree in bits [15:0].
- R10: A 2MB block carries `cmd_cont_o` = 1 when its aligned 32MB group (16 blocks) lies wholly inside the job and the addresses agree in bits [24:0]. Level-1 commands never carry the hint.
- R11: With `job_no_cont_i` = 1 no command carries the hint.
- R12: While `cmd_ready_i` is 0 a pending command holds all fields unchanged. Each command is taken exactly once, in rising virtual-address order, and `cmd_attr_o` equals the job's `job_attr_i`.
- R13: `done_o` pulses once, after the last command has been taken. `job_ready_o` is 0 from acceptance until that pulse. At most one of `done_o`, `err_o`, `cmd_valid_o` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| job_valid_i | input | 1 | Job offered |
| job_ready_o | output | 1 | Sequencer idle; job taken on valid and ready |
| job_va_i | input | AW | Virtual start address |
| job_pa_i | input | AW | Physical start address |
| job_len_i | input | LW | Region length in bytes |
| job_no_blk_i | input | 1 | Forbid level-1 and level-2 blocks |
| job_no_cont_i | input | 1 | Forbid contiguous hints |
| job_attr_i | input | ATTR_W | Attribute field copied to each command |
| cmd_valid_o | output | 1 | Command pending |
| cmd_ready_i | input | 1 | Consumer accepts command |
| cmd_level_o | output | 2 | 1 = 1GB block, 2 = 2MB block, 3 = 4KB page |
| cmd_va_o | output | AW | Virtual address of the entry |
| cmd_pa_o | output | AW | Physical address the entry maps |
| cmd_cont_o | output | 1 | Contiguous hint |
| cmd_attr_o | output | ATTR_W | Job attribute field |
| done_o | output | 1 | One-cycle pulse at job completion |
| err_o | output | 1 | One-cycle pulse on a refused job |

## Verification
The assertions check the following in every cycle:
- a stalled command holds still and virtual addresses rise from command to command;
- each level's output addresses are aligned to its entry size;
- hinted entries have matching low offsets, and level-1 entries never carry the hint;
- the done, error and valid outputs are mutually exclusive.

Some behaviour only the bench scenarios can show:
- whether the walk picks the largest fitting entry;
- that no entry is missing or extra, including at the unaligned head and tail of a region;
- the exact grouping of hints and the effect of the two policy flags;
- refusal of mismatched offsets and handling of empty jobs.

// File: rtl/region_map_pkg.sv
package region_map_pkg;

  typedef enum logic [1:0] {
    LVL_NONE = 2'd0,
    LVL_BLK1 = 2'd1,
    LVL_BLK2 = 2'd2,
    LVL_PAGE = 2'd3
  } lvl_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } st_e;

endpackage

// File: rtl/region_map_fit.sv
// Piece end at one block level and whether a block of that level fits there.
module region_map_fit #(
  parameter int EW = 50,
  parameter int SH = 30
) (
  input  logic [EW-1:0] cur_i,
  input  logic [EW-1:0] lim_i,
  input  logic [EW-1:0] pa_i,
  input  logic          no_blk_i,
  output logic [EW-1:0] end_o,
  output logic          fit_o
);
  localparam logic [EW-1:0] SPAN = {{(EW-1){1'b0}}, 1'b1} << SH;
  localparam logic [EW-1:0] LOW  = SPAN - 1'b1;

  logic [EW-1:0] nxt;

  assign nxt   = (cur_i & ~LOW) + SPAN;
  assign end_o = (nxt < lim_i) ? nxt : lim_i;
  assign fit_o = !no_blk_i && (((cur_i | end_o | pa_i) & LOW) == '0);
endmodule

// File: rtl/region_map_cont.sv
// Contiguous-group test: aligned group wholly inside the job, offsets agree.
module region_map_cont #(
  parameter int EW = 50,
  parameter int SH = 16
) (
  input  logic [EW-1:0] cur_i,
  input  logic [EW-1:0] vst_i,
  input  logic [EW-1:0] vend_i,
  input  logic [EW-1:0] pa_i,
  input  logic          no_cont_i,
  output logic          hint_o
);
  localparam logic [EW-1:0] SPAN = {{(EW-1){1'b0}}, 1'b1} << SH;
  localparam logic [EW-1:0] LOW  = SPAN - 1'b1;

  logic [EW-1:0] grp_lo, grp_hi;

  assign grp_lo = cur_i & ~LOW;
  assign grp_hi = grp_lo + SPAN;
  assign hint_o = !no_cont_i && (grp_lo >= vst_i) && (grp_hi <= vend_i) &&
                  (((cur_i ^ pa_i) & LOW) == '0);
endmodule

// File: rtl/region_map_seq.sv
module region_map_seq
  import region_map_pkg::*;
#(
  parameter int AW      = 48,
  parameter int LW      = 48,
  parameter int ATTR_W  = 8,
  parameter int PAGE_SH = 12,
  parameter int IDX_W   = 9,
  parameter int CONT_SH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              job_valid_i,
  output logic              job_ready_o,
  input  logic [AW-1:0]     job_va_i,
  input  logic [AW-1:0]     job_pa_i,
  input  logic [LW-1:0]     job_len_i,
  input  logic              job_no_blk_i,
  input  logic              job_no_cont_i,
  input  logic [ATTR_W-1:0] job_attr_i,
  output logic              cmd_valid_o,
  input  logic              cmd_ready_i,
  output logic [1:0]        cmd_level_o,
  output logic [AW-1:0]     cmd_va_o,
  output logic [AW-1:0]     cmd_pa_o,
  output logic              cmd_cont_o,
  output logic [ATTR_W-1:0] cmd_attr_o,
  output logic              done_o,
  output logic              err_o
);
  localparam int L2_SH = PAGE_SH + IDX_W;
  localparam int L1_SH = L2_SH + IDX_W;
  // headroom so start + length and boundary rounding never wrap
  localparam int EW    = ((AW > LW) ? AW : LW) + 2;

  localparam logic [EW-1:0] PG_SPAN  = {{(EW-1){1'b0}}, 1'b1} << PAGE_SH;
  localparam logic [EW-1:0] PG_LOW   = PG_SPAN - 1'b1;
  localparam logic [AW-1:0] PG_LOW_A = ({{(AW-1){1'b0}}, 1'b1} << PAGE_SH) - 1'b1;

  st_e               st_q;
  logic [EW-1:0]     cur_q, end_q, vst_q;
  logic [AW-1:0]     pa_q;
  logic              no_blk_q, no_cont_q;
  logic [ATTR_W-1:0] attr_q;
  logic              done_q, err_q;

  logic [EW-1:0] va_ext, lim_raw, pa_ext;
  logic          offs_bad, len_zero, take_job, fire;

  assign va_ext   = EW'(job_va_i);
  assign lim_raw  = (va_ext + EW'(job_len_i) + PG_LOW) & ~PG_LOW;
  assign offs_bad = |((job_va_i ^ job_pa_i) & PG_LOW_A);
  assign len_zero = (job_len_i == '0);
  assign take_job = job_valid_i && (st_q == ST_IDLE);
  assign pa_ext   = EW'(pa_q);

  // index 0: 1GB level / 32MB block groups; index 1: 2MB level / 64KB page groups
  logic [EW-1:0] lvl_end [2];
  logic [1:0]    lvl_fit;
  logic [1:0]    grp_hint;

  for (genvar g = 0; g < 2; g++) begin : g_lvl
    localparam int FSH = (g == 0) ? L1_SH : L2_SH;
    localparam int CSH = ((g == 0) ? L2_SH : PAGE_SH) + CONT_SH;

    region_map_fit #(.EW(EW), .SH(FSH)) u_fit (
      .cur_i    (cur_q),
      .lim_i    (end_q),
      .pa_i     (pa_ext),
      .no_blk_i (no_blk_q),
      .end_o    (lvl_end[g]),
      .fit_o    (lvl_fit[g])
    );

    region_map_cont #(.EW(EW), .SH(CSH)) u_cont (
      .cur_i     (cur_q),
      .vst_i     (vst_q),
      .vend_i    (end_q),
      .pa_i      (pa_ext),
      .no_cont_i (no_cont_q),
      .hint_o    (grp_hint[g])
    );
  end

  lvl_e          step_lvl;
  logic [EW-1:0] step_end;
  logic          step_cont;

  always_comb begin
    if (lvl_fit[0]) begin
      step_lvl  = LVL_BLK1;
      step_end  = lvl_end[0];
      step_cont = 1'b0;
    end else if (lvl_fit[1]) begin
      step_lvl  = LVL_BLK2;
      step_end  = lvl_end[1];
      step_cont = grp_hint[0];
    end else begin
      step_lvl  = LVL_PAGE;
      step_end  = cur_q + PG_SPAN;
      step_cont = grp_hint[1];
    end
  end

  assign cmd_valid_o = (st_q == ST_RUN) && (cur_q != end_q);
  assign fire        = cmd_valid_o && cmd_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      cur_q     <= '0;
      end_q     <= '0;
      vst_q     <= '0;
      pa_q      <= '0;
      no_blk_q  <= 1'b0;
      no_cont_q <= 1'b0;
      attr_q    <= '0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (take_job) begin
        if (offs_bad) begin
          err_q <= 1'b1;
        end else if (len_zero) begin
          done_q <= 1'b1;
        end else begin
          st_q      <= ST_RUN;
          cur_q     <= va_ext & ~PG_LOW;
          vst_q     <= va_ext & ~PG_LOW;
          end_q     <= lim_raw;
          pa_q      <= job_pa_i & ~PG_LOW_A;
          no_blk_q  <= job_no_blk_i;
          no_cont_q <= job_no_cont_i;
          attr_q    <= job_attr_i;
        end
      end else if (st_q == ST_RUN) begin
        if (cur_q == end_q) begin
          done_q <= 1'b1;
          st_q   <= ST_IDLE;
        end else if (fire) begin
          cur_q <= step_end;
          pa_q  <= pa_q + AW'(step_end - cur_q);
        end
      end
    end
  end

  assign job_ready_o = (st_q == ST_IDLE);
  assign cmd_level_o = step_lvl;
  assign cmd_va_o    = cur_q[AW-1:0];
  assign cmd_pa_o    = pa_q;
  assign cmd_cont_o  = step_cont;
  assign cmd_attr_o  = attr_q;
  assign done_o      = done_q;
  assign err_o       = err_q;
endmodule

// File: rtl/region_map_chk.sv
module region_map_chk #(
  parameter int AW      = 48,
  parameter int ATTR_W  = 8,
  parameter int PAGE_SH = 12,
  parameter int L2_SH   = 21,
  parameter int L1_SH   = 30,
  parameter int CONT_SH = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              job_ready_o,
  input logic              cmd_valid_o,
  input logic              cmd_ready_i,
  input logic [1:0]        cmd_level_o,
  input logic [AW-1:0]     cmd_va_o,
  input logic [AW-1:0]     cmd_pa_o,
  input logic              cmd_cont_o,
  input logic [ATTR_W-1:0] cmd_attr_o,
  input logic              done_o,
  input logic              err_o
);
  localparam int PG_G = PAGE_SH + CONT_SH;
  localparam int BK_G = L2_SH + CONT_SH;

  assert_hold_stall_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_va_o) && $stable(cmd_pa_o) &&
      $stable(cmd_level_o) && $stable(cmd_cont_o) && $stable(cmd_attr_o));

  assert_va_rises_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && cmd_ready_i |=> !cmd_valid_o || (cmd_va_o > $past(cmd_va_o)));

  assert_lvl_legal_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> cmd_level_o != 2'd0);

  assert_l1_align_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && cmd_level_o == 2'd1 |->
      cmd_va_o[L1_SH-1:0] == '0 && cmd_pa_o[L1_SH-1:0] == '0);

  assert_l2_align_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && cmd_level_o == 2'd2 |->
      cmd_va_o[L2_SH-1:0] == '0 && cmd_pa_o[L2_SH-1:0] == '0);

  assert_page_align_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> cmd_va_o[PAGE_SH-1:0] == '0 && cmd_pa_o[PAGE_SH-1:0] == '0);

  assert_l1_nocont_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && cmd_level_o == 2'd1 |-> !cmd_cont_o);

  assert_blk_cont_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && cmd_level_o == 2'd2 && cmd_cont_o |->
      cmd_va_o[BK_G-1:0] == cmd_pa_o[BK_G-1:0]);

  assert_page_cont_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && cmd_level_o == 2'd3 && cmd_cont_o |->
      cmd_va_o[PG_G-1:0] == cmd_pa_o[PG_G-1:0]);

  assert_excl_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({done_o, err_o, cmd_valid_o}));

  assert_idle_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    job_ready_o |-> !cmd_valid_o);
endmodule

bind region_map_seq region_map_chk #(
  .AW(AW), .ATTR_W(ATTR_W), .PAGE_SH(PAGE_SH),
  .L2_SH(L2_SH), .L1_SH(L1_SH), .CONT_SH(CONT_SH)
) u_chk (.*);

// File: tb/region_map_seq_test.sv
module region_map_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 48;
  localparam int LW = 48;
  localparam int ATTR_W = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              job_valid = 1'b0;
  logic              job_ready;
  logic [AW-1:0]     job_va = '0, job_pa = '0;
  logic [LW-1:0]     job_len = '0;
  logic              job_no_blk = 1'b0, job_no_cont = 1'b0;
  logic [ATTR_W-1:0] job_attr = '0;
  logic              cmd_valid, cmd_ready = 1'b0;
  logic [1:0]        cmd_level;
  logic [AW-1:0]     cmd_va, cmd_pa;
  logic              cmd_cont;
  logic [ATTR_W-1:0] cmd_attr;
  logic              done, err;

  always #(CLK_PERIOD/2) clk = ~clk;

  region_map_seq uut (
    .clk_i(clk), .rst_ni(rst_n),
    .job_valid_i(job_valid), .job_ready_o(job_ready),
    .job_va_i(job_va), .job_pa_i(job_pa), .job_len_i(job_len),
    .job_no_blk_i(job_no_blk), .job_no_cont_i(job_no_cont), .job_attr_i(job_attr),
    .cmd_valid_o(cmd_valid), .cmd_ready_i(cmd_ready),
    .cmd_level_o(cmd_level), .cmd_va_o(cmd_va), .cmd_pa_o(cmd_pa),
    .cmd_cont_o(cmd_cont), .cmd_attr_o(cmd_attr),
    .done_o(done), .err_o(err)
  );

  typedef struct {
    logic [1:0]      lvl;
    longint unsigned va;
    longint unsigned pa;
    bit              cont;
  } exp_t;

  exp_t  exp_q[$];
  int    n_chk = 0, n_fail = 0, n_cyc = 0;
  string cont_tag = "R9";
  logic [ATTR_W-1:0] exp_attr = '0;

  function automatic void chk(bit ok, string tag, longint unsigned act, longint unsigned expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endfunction

  function automatic longint unsigned umin(longint unsigned a, longint unsigned b);
    return (a < b) ? a : b;
  endfunction

  function automatic void push(logic [1:0] l, longint unsigned va, longint unsigned pa, bit c);
    exp_t e;
    e.lvl = l; e.va = va; e.pa = pa; e.cont = c;
    exp_q.push_back(e);
  endfunction

  // Hierarchical reference walk: 1GB pieces, 32MB groups, 2MB pieces, 64KB groups, pages
  task automatic model(longint unsigned va, longint unsigned pa, longint unsigned len, bit nb, bit nc);
    longint unsigned a, e, p, n1, ng, n2, n64, b, q;
    bit c, c2;
    if (len == 0) return;
    a = va & ~64'hFFF;
    p = pa & ~64'hFFF;
    e = (va + len + 64'hFFF) & ~64'hFFF;
    while (a != e) begin
      n1 = umin(((a >> 30) + 1) << 30, e);
      if (!nb && ((a | n1 | p) & 64'h3FFF_FFFF) == 0) push(2'd1, a, p, 1'b0);
      else begin
        b = a; q = p;
        while (b != n1) begin
          ng = umin(((b >> 25) + 1) << 25, n1);
          c  = !nc && ((b | ng | q) & 64'h1FF_FFFF) == 0;
          while (b != ng) begin
            n2 = umin(((b >> 21) + 1) << 21, ng);
            if (!nb && ((b | n2 | q) & 64'h1F_FFFF) == 0) begin
              push(2'd2, b, q, c);
              q += n2 - b; b = n2;
            end else begin
              while (b != n2) begin
                n64 = umin(((b >> 16) + 1) << 16, n2);
                c2  = c || (!nc && ((b | n64 | q) & 64'hFFFF) == 0);
                while (b != n64) begin
                  push(2'd3, b, q, c2);
                  b += 4096; q += 4096;
                end
              end
            end
          end
        end
      end
      p += n1 - a;
      a = n1;
    end
  endtask

  // Monitor: compares each handshake taken at the preceding rising edge
  logic [15:0] lfsr = 16'hACE1;
  logic        s_vld = 1'b0, s_rdy = 1'b0, s_cont = 1'b0;
  logic [1:0]  s_lvl = '0;
  logic [AW-1:0] s_va = '0, s_pa = '0;
  logic [ATTR_W-1:0] s_attr = '0;

  always @(negedge clk) begin
    n_cyc++;
    if (rst_n && s_vld && s_rdy) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R12 extra command", 64'(s_va), 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(s_lvl == e.lvl, (e.lvl == 2'd1) ? "R5 level" : (e.lvl == 2'd2) ? "R6 level" : "R7 level",
            64'(s_lvl), 64'(e.lvl));
        chk(64'(s_va) == e.va, "R7 va", 64'(s_va), e.va);
        chk(64'(s_pa) == e.pa, "R7 pa", 64'(s_pa), e.pa);
        chk(s_cont == e.cont, cont_tag, 64'(s_cont), 64'(e.cont));
        chk(s_attr == exp_attr, "R12 attr", 64'(s_attr), 64'(exp_attr));
      end
    end
    s_vld = cmd_valid; s_lvl = cmd_level; s_va = cmd_va; s_pa = cmd_pa;
    s_cont = cmd_cont; s_attr = cmd_attr;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    cmd_ready = rst_n && (lfsr[0] | lfsr[1]);
    s_rdy = cmd_ready;
  end

  task automatic finish_run();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (n_cyc > 150000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog R13 actual=%0d expected=<150000", n_cyc);
        finish_run();
      end
    end
  end

  task automatic run_job(string tag, string ctag, longint unsigned va, longint unsigned pa,
                         longint unsigned len, bit nb, bit nc, logic [ATTR_W-1:0] attr, bit exp_err);
    int waitc;
    bit multi;
    cont_tag = ctag;
    exp_attr = attr;
    if (!exp_err) model(va, pa, len, nb, nc);
    multi = exp_q.size() > 0;
    @(negedge clk);
    chk(job_ready == 1'b1, "R13 ready idle", 64'(job_ready), 1);
    job_va = va[AW-1:0]; job_pa = pa[AW-1:0]; job_len = len[LW-1:0];
    job_no_blk = nb; job_no_cont = nc; job_attr = attr; job_valid = 1'b1;
    @(negedge clk);
    job_valid = 1'b0;
    if (multi) chk(job_ready == 1'b0, "R13 busy", 64'(job_ready), 0);
    waitc = 0;
    while (!done && !err && waitc < 20000) begin
      @(negedge clk);
      waitc++;
    end
    chk(err == exp_err, exp_err ? "R2 err" : tag, 64'(err), 64'(exp_err));
    chk(done == !exp_err, exp_err ? "R2 no done" : "R13 done", 64'(done), 64'(!exp_err));
    chk(exp_q.size() == 0, {tag, " commands left"}, 64'(exp_q.size()), 0);
    exp_q.delete();
    @(negedge clk);
    chk(done == 1'b0 && err == 1'b0, "R13 single pulse", 64'({done, err}), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 2 + 1);
    chk(job_ready == 1'b1, "R1 ready", 64'(job_ready), 1);
    chk(cmd_valid == 1'b0, "R1 valid", 64'(cmd_valid), 0);
    chk(done == 1'b0 && err == 1'b0, "R1 pulses", 64'({done, err}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    run_job("R2", "R9", 64'h1234, 64'h5238, 64'h3000, 0, 0, 8'h11, 1);
    run_job("R3", "R9", 64'h1234, 64'h5234, 64'h0, 0, 0, 8'h12, 0);
    run_job("R4", "R9", 64'h1234, 64'h5234, 64'h3000, 0, 0, 8'h13, 0);
    run_job("R9", "R9", 64'h10000, 64'h40000, 64'h20000, 0, 0, 8'h14, 0);
    run_job("R11", "R11", 64'h10000, 64'h40000, 64'h20000, 0, 1, 8'h15, 0);
    run_job("R6", "R10", 64'h200000, 64'h400000, 64'h400000, 0, 0, 8'h16, 0);
    run_job("R10", "R10", 64'h2000000, 64'h6000000, 64'h2000000, 0, 0, 8'h17, 0);
    run_job("R11", "R11", 64'h2000000, 64'h6000000, 64'h2000000, 0, 1, 8'h18, 0);
    run_job("R5", "R10", 64'h40000000, 64'h80000000, 64'h40000000, 0, 0, 8'h19, 0);
    run_job("R5", "R10", 64'h3FE00000, 64'hBFE00000, 64'h40400000, 0, 0, 8'h1A, 0);
    run_job("R8", "R9", 64'h200000, 64'h400000, 64'h400000, 1, 0, 8'h1B, 0);
    run_job("R6", "R9", 64'h200000, 64'h201000, 64'h200000, 0, 0, 8'h1C, 0);
    run_job("R12", "R9", 64'h7FFF0000, 64'h3FFF0000, 64'h30000, 0, 0, 8'h1D, 0);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule